// File: doc/BRIEF.md
# Two-Phase Interleaved PWM with Single-Sense Current Balancing

This block drives the gates of two converter phases that share one switching period and are offset by half a period. Both phases take the same duty command from an external voltage loop. Each phase then adds its own balancing correction to that command. The sum is clamped so that an on-window always stays shorter than half a period. Because the two on-windows can then never overlap, one current-sense channel is enough for both phases. A sample that arrives while a phase's gate is high belongs to that phase.

For each phase, the block averages the samples taken inside that phase's on-window and stores the result as the phase's reading. Once per period, an integrator per phase compares its reading with a sharing reference and moves its correction toward balance. The reference is either the average of the two readings or the larger of the two. When the second phase is switched off, its gate stays low and both corrections are forced to zero, so phase 1 runs on the bare command.

Top module: `ilv_share_pwm`

## Requirements
- R1: During reset both gates are low and both stored readings are zero. All corrections and latched duties are also zero.
- R2: The period is PERIOD clocks, counted 0 to PERIOD-1. Phase 1's gate is high while count < its duty. Phase 2's gate is high while count >= PERIOD/2 and count-PERIOD/2 < its duty. A phase-2 window therefore starts exactly PERIOD/2 clocks after a phase-1 window.
- R3: A phase's final duty is the command plus that phase's correction, clamped to at least 0 and at most PERIOD/2-1-dead_margin. When dead_margin is too large for that limit to be positive, the upper limit is 0.
- R4: The two gates are never high in the same cycle.
- R5: A sample with sense_valid high is credited only to the phase whose gate is high in that cycle. Samples taken while both gates are low are ignored.
- R6: A phase's reading is the floor of the mean of the samples credited to it in its half-period slot. Phase 1's reading is latched at count PERIOD/2-1 and phase 2's at count PERIOD-1, and each becomes visible in the next cycle.
- R7: A slot with no credited samples leaves that phase's reading unchanged.
- R8: Each correction is updated once per period, in the cycle where count is 0. The update adds (reference - own reading) arithmetically shifted right by gain_shift and saturates at +/-INT_LIM. The duties are latched in the cycle where count is PERIOD-1 and apply to the whole next period.
- R9: With ref_sel = 0 the reference is floor((reading1+reading2)/2). With ref_sel = 1 it is the larger reading.
- R10: While ph2_en is low, gate2 stays low and both corrections are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_cmd | input | $clog2(PERIOD) | Common duty command from the voltage loop, in clocks |
| dead_margin | input | $clog2(PERIOD) | Clocks taken off the half-period duty limit |
| ph2_en | input | 1 | Enables phase 2 and the balancing loop |
| ref_sel | input | 1 | Sharing reference: 0 average, 1 larger reading |
| gain_shift | input | SH_W | Right shift applied to the integrator error |
| sense_valid | input | 1 | Qualifies sense_cur in this cycle |
| sense_cur | input | CUR_W | Shared current-sense sample |
| gate1 | output | 1 | Phase 1 gate drive |
| gate2 | output | 1 | Phase 2 gate drive |
| cur1 | output | CUR_W | Stored phase 1 reading |
| cur2 | output | CUR_W | Stored phase 2 reading |

## Verification
The gates follow the registered counter in the same cycle. A reading appears one cycle after its slot-end edge. A correction moves at the edge that leaves count 0, and it reaches the gates only through the duty latched at count PERIOD-1, so a sense change shows up at the gates one to two periods later. The reference model is advanced at each rising edge using the inputs held since the previous falling edge. It is compared with both gates and both readings at every falling edge, which keeps every check aligned with that latency. Directed checks of high-time, phase offset and readings are taken only after several full periods have passed, once the duties and integrators are steady.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic {
    REF_AVG = 1'b0,
    REF_MAX = 1'b1
  } share_ref_e;
endpackage

// File: rtl/ilv_period_ctr.sv
module ilv_period_ctr #(
  parameter int PERIOD = 64,
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             tc,
  output logic             mid,
  output logic             start
);
  localparam int HALF = PERIOD / 2;

  logic [CNT_W-1:0] cnt_n;

  assign tc    = (cnt == CNT_W'(PERIOD - 1));
  assign mid   = (cnt == CNT_W'(HALF - 1));
  assign start = (cnt == '0);

  always_comb begin
    cnt_n = tc ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/ilv_phase_meter.sv
module ilv_phase_meter #(
  parameter int CUR_W = 12,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_win,
  input  logic             win_end,
  input  logic             sense_valid,
  input  logic [CUR_W-1:0] sense_cur,
  output logic [CUR_W-1:0] rd
);
  localparam int SUM_W = CUR_W + CNT_W;
  localparam int N_W   = CNT_W + 1;

  logic [SUM_W-1:0] sum_q, sum_n, sum_acc;
  logic [N_W-1:0]   n_q, n_n, n_acc;
  logic [CUR_W-1:0] rd_n;
  logic             take;

  always_comb begin
    take    = in_win & sense_valid;
    sum_acc = sum_q + (take ? SUM_W'(sense_cur) : '0);
    n_acc   = n_q + N_W'(take);
    sum_n   = sum_acc;
    n_n     = n_acc;
    rd_n    = rd;
    if (win_end) begin
      sum_n = '0;
      n_n   = '0;
      if (n_acc != '0) rd_n = CUR_W'(sum_acc / SUM_W'(n_acc));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      n_q   <= '0;
      rd    <= '0;
    end else begin
      sum_q <= sum_n;
      n_q   <= n_n;
      rd    <= rd_n;
    end
  end
endmodule

// File: rtl/ilv_share_integ.sv
module ilv_share_integ #(
  parameter int CUR_W   = 12,
  parameter int INT_W   = 10,
  parameter int INT_LIM = 20,
  parameter int SH_W    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd,
  input  logic                    ph2_en,
  input  logic                    ref_max,
  input  logic [CUR_W-1:0]        cur_a,
  input  logic [CUR_W-1:0]        cur_b,
  input  logic [SH_W-1:0]         gain_shift,
  output logic signed [INT_W-1:0] corr_a,
  output logic signed [INT_W-1:0] corr_b
);
  localparam int EW   = CUR_W + 1;
  localparam int SUMW = INT_W + CUR_W + 2;

  logic [CUR_W:0]   pair_sum;
  logic [CUR_W-1:0] ref_c;

  always_comb begin
    pair_sum = {1'b0, cur_a} + {1'b0, cur_b};
    if (ref_max) ref_c = (cur_a > cur_b) ? cur_a : cur_b;
    else         ref_c = pair_sum[CUR_W:1];
  end

  for (genvar k = 0; k < 2; k++) begin : g_int
    logic [CUR_W-1:0]        own;
    logic signed [EW-1:0]    err, step;
    logic signed [SUMW-1:0]  acc;
    logic signed [INT_W-1:0] sat, integ_q, integ_n;

    assign own = (k == 0) ? cur_a : cur_b;

    always_comb begin
      err  = $signed({1'b0, ref_c}) - $signed({1'b0, own});
      step = err >>> gain_shift;
      acc  = SUMW'(integ_q) + SUMW'(step);
      if (acc > SUMW'(INT_LIM))       sat = INT_W'(INT_LIM);
      else if (acc < SUMW'(-INT_LIM)) sat = INT_W'(-INT_LIM);
      else                            sat = INT_W'(acc);
      if (!ph2_en)  integ_n = '0;
      else if (upd) integ_n = sat;
      else          integ_n = integ_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) integ_q <= '0;
      else        integ_q <= integ_n;
    end
  end

  assign corr_a = g_int[0].integ_q;
  assign corr_b = g_int[1].integ_q;
endmodule

// File: rtl/ilv_share_pwm.sv
module ilv_share_pwm
  import ilv_pkg::*;
#(
  parameter int PERIOD  = 64,
  parameter int CUR_W   = 12,
  parameter int INT_W   = 10,
  parameter int INT_LIM = 20,
  parameter int SH_W    = 3,
  localparam int CNT_W  = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] duty_cmd,
  input  logic [CNT_W-1:0] dead_margin,
  input  logic             ph2_en,
  input  logic             ref_sel,
  input  logic [SH_W-1:0]  gain_shift,
  input  logic             sense_valid,
  input  logic [CUR_W-1:0] sense_cur,
  output logic             gate1,
  output logic             gate2,
  output logic [CUR_W-1:0] cur1,
  output logic [CUR_W-1:0] cur2
);
  localparam int HALF = PERIOD / 2;
  localparam int SW   = INT_W + CNT_W + 2;

  logic [CNT_W-1:0]        cnt;
  logic                    tc, mid, start;
  logic signed [INT_W-1:0] corr_a, corr_b;
  logic signed [SW-1:0]    lim_raw, lim_c;
  logic [CNT_W-1:0]        duty_a_q, duty_b_q;
  share_ref_e              ref_mode;

  assign ref_mode = share_ref_e'(ref_sel);

  ilv_period_ctr #(.PERIOD(PERIOD)) u_ctr (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .tc(tc), .mid(mid), .start(start)
  );

  ilv_share_integ #(
    .CUR_W(CUR_W), .INT_W(INT_W), .INT_LIM(INT_LIM), .SH_W(SH_W)
  ) u_integ (
    .clk(clk), .rst_n(rst_n), .upd(start), .ph2_en(ph2_en),
    .ref_max(ref_mode == REF_MAX), .cur_a(cur1), .cur_b(cur2),
    .gain_shift(gain_shift), .corr_a(corr_a), .corr_b(corr_b)
  );

  always_comb begin
    lim_raw = SW'(HALF - 1) - $signed(SW'(dead_margin));
    lim_c   = (lim_raw < 0) ? '0 : lim_raw;
  end

  for (genvar k = 0; k < 2; k++) begin : g_ph
    logic signed [INT_W-1:0] corr_k;
    logic signed [SW-1:0]    raw;
    logic [CNT_W-1:0]        duty_c, duty_n, duty_q;
    logic                    win, slot_end;
    logic [CUR_W-1:0]        rd;

    assign corr_k   = (k == 0) ? corr_a : corr_b;
    assign slot_end = (k == 0) ? mid : tc;

    always_comb begin
      raw = $signed(SW'(duty_cmd)) + SW'(corr_k);
      if (raw < 0)          duty_c = '0;
      else if (raw > lim_c) duty_c = CNT_W'(lim_c);
      else                  duty_c = CNT_W'(raw);
      duty_n = tc ? duty_c : duty_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) duty_q <= '0;
      else        duty_q <= duty_n;
    end

    if (k == 0) begin : g_win_lead
      assign win = (cnt < duty_q);
    end else begin : g_win_lag
      assign win = ph2_en && (cnt >= CNT_W'(HALF)) &&
                   ((cnt - CNT_W'(HALF)) < duty_q);
    end

    ilv_phase_meter #(.CUR_W(CUR_W), .CNT_W(CNT_W)) u_meter (
      .clk(clk), .rst_n(rst_n), .in_win(win), .win_end(slot_end),
      .sense_valid(sense_valid), .sense_cur(sense_cur), .rd(rd)
    );
  end

  assign duty_a_q = g_ph[0].duty_q;
  assign duty_b_q = g_ph[1].duty_q;
  assign gate1    = g_ph[0].win;
  assign gate2    = g_ph[1].win;
  assign cur1     = g_ph[0].rd;
  assign cur2     = g_ph[1].rd;
endmodule

// File: rtl/ilv_share_pwm_chk.sv
module ilv_share_pwm_chk #(
  parameter int PERIOD  = 64,
  parameter int CUR_W   = 12,
  parameter int INT_W   = 10,
  parameter int INT_LIM = 20,
  localparam int CNT_W  = $clog2(PERIOD)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ph2_en,
  input logic                    gate1,
  input logic                    gate2,
  input logic [CNT_W-1:0]        cnt,
  input logic [CNT_W-1:0]        duty_a_q,
  input logic [CNT_W-1:0]        duty_b_q,
  input logic signed [INT_W-1:0] corr_a,
  input logic signed [INT_W-1:0] corr_b,
  input logic [CUR_W-1:0]        cur1
);
  localparam int HALF = PERIOD / 2;

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate1 && gate2));

  // R10
  ph2_off_corr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ph2_en |=> (corr_a == '0 && corr_b == '0));

  // R3
  duty_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_a_q < CNT_W'(HALF)) && (duty_b_q < CNT_W'(HALF)));

  // R8
  corr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_a <= INT_W'(INT_LIM)) && (corr_a >= INT_W'(-INT_LIM)) &&
    (corr_b <= INT_W'(INT_LIM)) && (corr_b >= INT_W'(-INT_LIM)));

  // R8
  duty_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty_a_q) |-> (cnt == '0));

  // R2
  lag_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate2) |-> (cnt == CNT_W'(HALF)));

  // R6
  rd_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur1) |-> (cnt == CNT_W'(HALF)));
endmodule

bind ilv_share_pwm ilv_share_pwm_chk #(
  .PERIOD(PERIOD), .CUR_W(CUR_W), .INT_W(INT_W), .INT_LIM(INT_LIM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ph2_en(ph2_en), .gate1(gate1), .gate2(gate2),
  .cnt(cnt), .duty_a_q(duty_a_q), .duty_b_q(duty_b_q),
  .corr_a(corr_a), .corr_b(corr_b), .cur1(cur1)
);

// File: tb/tb_ilv_share_pwm.sv
module tb_ilv_share_pwm;
  localparam int P   = 64;
  localparam int H   = P / 2;
  localparam int LIM = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  duty_cmd, dead_margin;
  logic        ph2_en, ref_sel, sense_valid;
  logic [2:0]  gain_shift;
  logic [11:0] sense_cur;
  logic        gate1, gate2;
  logic [11:0] cur1, cur2;

  int checks = 0;
  int failures = 0;
  int val_a, val_b;
  bit alt_en, tog;

  always #10 clk = ~clk;

  ilv_share_pwm dut (
    .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .dead_margin(dead_margin),
    .ph2_en(ph2_en), .ref_sel(ref_sel), .gain_shift(gain_shift),
    .sense_valid(sense_valid), .sense_cur(sense_cur),
    .gate1(gate1), .gate2(gate2), .cur1(cur1), .cur2(cur2)
  );

  // behavioural reference state
  int m_cnt, md1, md2, mi1, mi2, mc1, mc2, ms1, mn1, ms2, mn2;

  function automatic int clampd(int raw, int dead);
    int lim;
    lim = H - 1 - dead;
    if (lim < 0) lim = 0;
    if (raw < 0) return 0;
    if (raw > lim) return lim;
    return raw;
  endfunction

  function automatic int satl(int v);
    if (v > LIM) return LIM;
    if (v < -LIM) return -LIM;
    return v;
  endfunction

  function automatic bit mg1();
    return m_cnt < md1;
  endfunction

  function automatic bit mg2();
    return ph2_en && (m_cnt >= H) && ((m_cnt - H) < md2);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; md1 = 0; md2 = 0; mi1 = 0; mi2 = 0; mc1 = 0; mc2 = 0;
      ms1 = 0; mn1 = 0; ms2 = 0; mn2 = 0;
    end else begin
      bit g1, g2;
      int rv;
      g1 = mg1();
      g2 = mg2();
      if (sense_valid && g1) begin ms1 += int'(sense_cur); mn1++; end
      if (sense_valid && g2) begin ms2 += int'(sense_cur); mn2++; end
      if (m_cnt == P - 1) begin
        md1 = clampd(int'(duty_cmd) + mi1, int'(dead_margin));
        md2 = clampd(int'(duty_cmd) + mi2, int'(dead_margin));
      end
      if (m_cnt == 0) begin
        rv  = ref_sel ? ((mc1 > mc2) ? mc1 : mc2) : (mc1 + mc2) / 2;
        mi1 = satl(mi1 + ((rv - mc1) >>> gain_shift));
        mi2 = satl(mi2 + ((rv - mc2) >>> gain_shift));
      end
      if (!ph2_en) begin mi1 = 0; mi2 = 0; end
      if (m_cnt == H - 1) begin
        if (mn1 > 0) mc1 = ms1 / mn1;
        ms1 = 0; mn1 = 0;
      end
      if (m_cnt == P - 1) begin
        if (mn2 > 0) mc2 = ms2 / mn2;
        ms2 = 0; mn2 = 0;
      end
      m_cnt = (m_cnt + 1) % P;
    end
  end

  // per-cycle comparison and sense stimulus
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (gate1 !== mg1() || gate2 !== mg2() || int'(cur1) != mc1 || int'(cur2) != mc2) begin
        failures++;
        $display("FAIL R2 R5 R6 R8 R9 model: actual g1=%0d g2=%0d c1=%0d c2=%0d expected g1=%0d g2=%0d c1=%0d c2=%0d",
                 gate1, gate2, cur1, cur2, mg1(), mg2(), mc1, mc2);
      end
    end
    if (gate1) begin
      sense_cur <= 12'(val_a + ((alt_en && tog) ? 3 : 0));
      tog = ~tog;
    end else if (gate2) sense_cur <= 12'(val_b);
    else sense_cur <= 12'd999;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(output int h1, output int h2);
    h1 = 0; h2 = 0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      h1 += int'(gate1);
      h2 += int'(gate2);
    end
  endtask

  task automatic rise_gap(output int gap);
    bit prev;
    prev = 1'b1;
    gap = -1;
    for (int i = 0; i < 2 * P; i++) begin
      @(negedge clk);
      if (gate1 && !prev) begin gap = 0; break; end
      prev = gate1;
    end
    if (gap == 0) begin
      for (int i = 0; i < P; i++) begin
        @(negedge clk);
        gap++;
        if (gate2) break;
      end
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    int h1, h2, gap;
    rst_n = 1'b0; duty_cmd = 6'd10; dead_margin = 6'd2; ph2_en = 1'b0;
    ref_sel = 1'b0; gain_shift = 3'd2; sense_valid = 1'b1; sense_cur = '0;
    val_a = 100; val_b = 100; alt_en = 1'b1; tog = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 gate1", int'(gate1), 0);
    chk("R1 gate2", int'(gate2), 0);
    chk("R1 cur1", int'(cur1), 0);
    chk("R1 cur2", int'(cur2), 0);
    rst_n = 1'b1;

    // single phase, alternating 100/103 samples
    repeat (6 * P) @(negedge clk);
    measure(h1, h2);
    chk("R10 phase1 high time with zero correction", h1, 10);
    chk("R10 gate2 held low", h2, 0);
    chk("R6 floor mean of window", int'(cur1), 101);

    duty_cmd = 6'd60;
    repeat (4 * P) @(negedge clk);
    measure(h1, h2);
    chk("R3 upper clamp", h1, 29);
    chk("R6 mean over clamped window", int'(cur1), 101);

    dead_margin = 6'd40;
    repeat (3 * P) @(negedge clk);
    val_a = 200; alt_en = 1'b0;
    repeat (3 * P) @(negedge clk);
    measure(h1, h2);
    chk("R3 limit collapses to zero", h1, 0);
    chk("R7 reading kept without samples", int'(cur1), 101);

    // two phases, average reference, unequal currents
    dead_margin = 6'd2; duty_cmd = 6'd20; val_a = 300; val_b = 100;
    ph2_en = 1'b1;
    repeat (12 * P) @(negedge clk);
    measure(h1, h2);
    chk("R8 negative saturation drives phase1 to zero", h1, 0);
    chk("R3 phase2 clamp", h2, 29);
    chk("R5 phase1 reading", int'(cur1), 300);
    chk("R5 phase2 reading ignores idle samples", int'(cur2), 100);

    // disable, then larger-current reference
    ph2_en = 1'b0;
    measure(h1, h2);
    chk("R10 gate2 low while disabled", h2, 0);
    repeat (P) @(negedge clk);
    ref_sel = 1'b1; duty_cmd = 6'd5; dead_margin = 6'd0; ph2_en = 1'b1;
    repeat (10 * P) @(negedge clk);
    measure(h1, h2);
    chk("R9 max reference leaves larger phase uncorrected", h1, 5);
    chk("R8 positive saturation at limit", h2, 25);
    rise_gap(gap);
    chk("R2 half-period offset", gap, H);

    finish_run();
  end
endmodule